// File: doc/BRIEF.md
# Dual-Rank Memory Command Decoder

This block sits on the device side of a DDR3-style command bus shared by two ranks. On every rising clock edge it registers the per-rank chip selects, the three active-low command lines, the bank address and the address bus. In the following cycle it turns the registered values into a one-hot command strobe, tagged with the rank that was addressed. Each command comes with the qualifiers that ride on the address and bank lines: auto-precharge, precharge-all, burst chop and the mode register index. The row or column address, or the mode op-code, comes out beside it.

Per rank and bank, the decoder keeps an open bit and the row that was last activated. It reports this row with every read or write. It flags two kinds of fault. One is a read or write to a bank that has no open row. The other is an activate to a bank that is already open. Each rank also records, from its last load of mode register 0, whether on-the-fly burst chop is enabled. This setting decides how A12 is read on column commands. Power states, data transfer and timing checks are not part of this block.

Top module: `dramcmd_decoder`

## Requirements
- R1: Chip-select bit 0 low addresses rank 0 and bit 1 low addresses rank 1; `cmd_rank` reports the rank. With both selects high, no strobe is raised, no flag is set and no bank or mode state changes, whatever the command lines carry.
- R2: With exactly one select low, the command lines {row, column, write} decode as 111 no-op (no strobe), 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 load mode and 110 calibration. The strobe bits of `cmd_stb` are ordered 0 activate, 1 read, 2 write, 3 precharge, 4 refresh, 5 load mode, 6 calibration. At most one bit is set. Results appear at the outputs two rising edges after the inputs are presented.
- R3: Both selects low in one cycle raises `err_multi_cs` for one output cycle. No strobe is raised and no state changes.
- R4: On a read or write, `cmd_autopre` equals A10. When A10 is high, the addressed bank is closed after that command.
- R5: On a precharge with A10 low, only the bank on `in_bank` of that rank is closed. With A10 high, every bank of that rank is closed and `cmd_preall` is set.
- R6: A load mode with bank value 0 (mode register 0) sets the rank's chop enable when address bits [1:0] equal 01, and clears it otherwise. On a read or write, `cmd_chop` is 1 exactly when the rank's chop enable is set and A12 is low. Chop enables start cleared.
- R7: `err_sequence` is set on a read or write to a bank with no open row. It is also set on an activate to a bank that is already open; in that case the stored row is kept. The strobe is still raised in both cases.
- R8: On a load mode, `cmd_mrsel` carries bank bits [1:0] and `cmd_row` carries the full address as the op-code.
- R9: An activate reports its address on `cmd_row` and opens the bank with that row. A read or write reports the open row of its bank on `cmd_row` (0 if the bank is closed) and the column on `cmd_col`: {A11, A9..A0} for x4 and A9..A0 for x8. `cmd_bank` is reported for activate, read, write and precharge, and is 0 otherwise. Every output field not named for a command is 0.
- R10: While reset is high, all outputs are 0. Reset closes every bank and clears both chop enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_sel_n | input | 2 | Per-rank chip selects, active low |
| in_op_n | input | 3 | Command lines {row strobe, column strobe, write}, active low |
| in_bank | input | 3 | Bank address |
| in_addr | input | 15 | Address bus |
| cmd_stb | output | 7 | One-hot command strobe |
| cmd_rank | output | 1 | Rank of the decoded command |
| cmd_bank | output | 3 | Bank of the decoded command |
| cmd_row | output | 15 | Row, open row or mode op-code |
| cmd_col | output | 11 | Column address of read or write |
| cmd_autopre | output | 1 | Auto-precharge qualifier |
| cmd_preall | output | 1 | Precharge applies to all banks |
| cmd_chop | output | 1 | Four-beat burst chop |
| cmd_mrsel | output | 2 | Mode register index |
| err_multi_cs | output | 1 | More than one rank selected |
| err_sequence | output | 1 | Open/closed bank sequence violation |

## Verification
The bank-state lookup and the bank-state update can meet on one command. A read or write with A10 high may target a bank that is already closed, which raises the sequence flag and requests a close in the same cycle. An activate may also follow a precharge of the same bank on the very next cycle, so the lookup must see the update just written. Directed back-to-back sequences create both cases, and long random runs mix them further. Each output cycle is judged field by field against a bench model that applies the lookup first and the update after.

// File: rtl/dcd_pkg.sv
`timescale 1ns/1ps
package dcd_pkg;

  typedef enum logic [2:0] {
    OP_NONE, OP_ACT, OP_RD, OP_WR, OP_PRE, OP_REF, OP_MRS, OP_ZQ
  } op_e;

  localparam int N_STB = 7;
  localparam int S_ACT = 0;
  localparam int S_RD  = 1;
  localparam int S_WR  = 2;
  localparam int S_PRE = 3;
  localparam int S_REF = 4;
  localparam int S_MRS = 5;
  localparam int S_ZQ  = 6;

  function automatic logic [N_STB-1:0] op_to_stb(input op_e op);
    logic [N_STB-1:0] s;
    s = '0;
    case (op)
      OP_ACT:  s[S_ACT] = 1'b1;
      OP_RD:   s[S_RD]  = 1'b1;
      OP_WR:   s[S_WR]  = 1'b1;
      OP_PRE:  s[S_PRE] = 1'b1;
      OP_REF:  s[S_REF] = 1'b1;
      OP_MRS:  s[S_MRS] = 1'b1;
      OP_ZQ:   s[S_ZQ]  = 1'b1;
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dcd_capture.sv
`timescale 1ns/1ps
module dcd_capture #(
  parameter int RANKS  = 2,
  parameter int BANK_W = 3,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RANKS-1:0]  sel_n_d,
  input  logic [2:0]        op_n_d,
  input  logic [BANK_W-1:0] bank_d,
  input  logic [ADDR_W-1:0] addr_d,
  output logic [RANKS-1:0]  sel_n_q,
  output logic [2:0]        op_n_q,
  output logic [BANK_W-1:0] bank_q,
  output logic [ADDR_W-1:0] addr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_n_q <= '1;
      op_n_q  <= '1;
      bank_q  <= '0;
      addr_q  <= '0;
    end else begin
      sel_n_q <= sel_n_d;
      op_n_q  <= op_n_d;
      bank_q  <= bank_d;
      addr_q  <= addr_d;
    end
  end

endmodule

// File: rtl/dcd_classify.sv
`timescale 1ns/1ps
module dcd_classify
  import dcd_pkg::*;
#(
  parameter int RANKS = 2,
  localparam int RW   = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int CW   = $clog2(RANKS + 1)
) (
  input  logic [RANKS-1:0] sel_n,
  input  logic [2:0]       op_n,
  output op_e              op,
  output logic [RW-1:0]    rank,
  output logic             multi
);

  logic [CW-1:0] n_low;
  op_e           raw;

  always_comb begin
    n_low = '0;
    rank  = '0;
    for (int r = 0; r < RANKS; r++) begin
      if (!sel_n[r]) begin
        n_low = n_low + 1'b1;
        rank  = RW'(r);
      end
    end
  end

  always_comb begin
    case (op_n)
      3'b011:  raw = OP_ACT;
      3'b101:  raw = OP_RD;
      3'b100:  raw = OP_WR;
      3'b010:  raw = OP_PRE;
      3'b001:  raw = OP_REF;
      3'b000:  raw = OP_MRS;
      3'b110:  raw = OP_ZQ;
      default: raw = OP_NONE;
    endcase
  end

  assign multi = (n_low > CW'(1));
  assign op    = (n_low == CW'(1)) ? raw : OP_NONE;

endmodule

// File: rtl/dcd_rank_state.sv
`timescale 1ns/1ps
module dcd_rank_state #(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 15,
  localparam int BANKS = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] bank,
  input  logic              open_en,
  input  logic              close_en,
  input  logic              close_all,
  input  logic [ADDR_W-1:0] row_d,
  input  logic              mode_we,
  input  logic              mode_chop,
  output logic [BANKS-1:0]  open_vec,
  output logic [ADDR_W-1:0] row_q,
  output logic              chop_en
);

  logic [BANKS-1:0]  open_r;
  logic [ADDR_W-1:0] rows [BANKS];

  always_ff @(posedge clk) begin
    if (rst) begin
      open_r <= '0;
    end else if (close_all) begin
      open_r <= '0;
    end else begin
      if (open_en)  open_r[bank] <= 1'b1;
      if (close_en) open_r[bank] <= 1'b0;
    end
  end

  // row table without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (open_en) rows[bank] <= row_d;
  end

  always_ff @(posedge clk) begin
    if (rst)          chop_en <= 1'b0;
    else if (mode_we) chop_en <= mode_chop;
  end

  assign open_vec = open_r;
  assign row_q    = rows[bank];

endmodule

// File: rtl/dramcmd_decoder.sv
`timescale 1ns/1ps
module dramcmd_decoder
  import dcd_pkg::*;
#(
  parameter int  RANKS  = 2,
  parameter int  BANK_W = 3,
  parameter int  ADDR_W = 15,
  parameter bit  DEV_X4 = 1'b1,
  localparam int RW     = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int COL_W  = DEV_X4 ? 11 : 10,
  localparam int BANKS  = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RANKS-1:0]  in_sel_n,
  input  logic [2:0]        in_op_n,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ADDR_W-1:0] in_addr,
  output logic [N_STB-1:0]  cmd_stb,
  output logic [RW-1:0]     cmd_rank,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              cmd_autopre,
  output logic              cmd_preall,
  output logic              cmd_chop,
  output logic [1:0]        cmd_mrsel,
  output logic              err_multi_cs,
  output logic              err_sequence
);

  localparam int AP_BIT = 10;
  localparam int BC_BIT = 12;

  logic [RANKS-1:0]  sel_q;
  logic [2:0]        op_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;

  dcd_capture #(.RANKS(RANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst),
    .sel_n_d(in_sel_n), .op_n_d(in_op_n), .bank_d(in_bank), .addr_d(in_addr),
    .sel_n_q(sel_q), .op_n_q(op_q), .bank_q(bank_q), .addr_q(addr_q)
  );

  op_e          op;
  logic [RW-1:0] rank;
  logic         multi;

  dcd_classify #(.RANKS(RANKS)) u_cls (
    .sel_n(sel_q), .op_n(op_q), .op(op), .rank(rank), .multi(multi)
  );

  logic [BANKS-1:0]  open_vec [RANKS];
  logic [ADDR_W-1:0] row_rd   [RANKS];
  logic              chop_en  [RANKS];

  logic is_act, is_rdwr, is_pre, is_mrs, bank_open, seq_bad;
  logic ap_bit;

  assign ap_bit    = addr_q[AP_BIT];
  assign is_act    = (op == OP_ACT);
  assign is_rdwr   = (op == OP_RD) || (op == OP_WR);
  assign is_pre    = (op == OP_PRE);
  assign is_mrs    = (op == OP_MRS);
  assign bank_open = open_vec[rank][bank_q];
  assign seq_bad   = (is_rdwr && !bank_open) || (is_act && bank_open);

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    logic hit;
    assign hit = (rank == RW'(r)) && (op != OP_NONE);
    dcd_rank_state #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_st (
      .clk(clk), .rst(rst), .bank(bank_q),
      .open_en(hit && is_act && !bank_open),
      .close_en(hit && ((is_pre && !ap_bit) || (is_rdwr && ap_bit))),
      .close_all(hit && is_pre && ap_bit),
      .row_d(addr_q),
      .mode_we(hit && is_mrs && (bank_q == '0)),
      .mode_chop(addr_q[1:0] == 2'b01),
      .open_vec(open_vec[r]), .row_q(row_rd[r]), .chop_en(chop_en[r])
    );
  end

  logic [COL_W-1:0] col_sel;
  if (DEV_X4) begin : g_x4
    assign col_sel = {addr_q[11], addr_q[9:0]};
  end else begin : g_x8
    assign col_sel = addr_q[9:0];
  end

  logic [ADDR_W-1:0] row_nx;
  always_comb begin
    row_nx = '0;
    if (is_act || is_mrs)          row_nx = addr_q;
    else if (is_rdwr && bank_open) row_nx = row_rd[rank];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_stb      <= '0;
      cmd_rank     <= '0;
      cmd_bank     <= '0;
      cmd_row      <= '0;
      cmd_col      <= '0;
      cmd_autopre  <= 1'b0;
      cmd_preall   <= 1'b0;
      cmd_chop     <= 1'b0;
      cmd_mrsel    <= '0;
      err_multi_cs <= 1'b0;
      err_sequence <= 1'b0;
    end else begin
      cmd_stb      <= op_to_stb(op);
      cmd_rank     <= (op != OP_NONE) ? rank : '0;
      cmd_bank     <= (is_act || is_rdwr || is_pre) ? bank_q : '0;
      cmd_row      <= row_nx;
      cmd_col      <= is_rdwr ? col_sel : '0;
      cmd_autopre  <= is_rdwr && ap_bit;
      cmd_preall   <= is_pre && ap_bit;
      cmd_chop     <= is_rdwr && chop_en[rank] && !addr_q[BC_BIT];
      cmd_mrsel    <= is_mrs ? bank_q[1:0] : 2'b00;
      err_multi_cs <= multi;
      err_sequence <= seq_bad;
    end
  end

endmodule

// File: rtl/dcd_checker.sv
`timescale 1ns/1ps
module dcd_checker
  import dcd_pkg::*;
#(
  parameter int COL_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic [N_STB-1:0] cmd_stb,
  input logic [COL_W-1:0] cmd_col,
  input logic             cmd_autopre,
  input logic             cmd_preall,
  input logic             cmd_chop,
  input logic [1:0]       cmd_mrsel,
  input logic             err_multi_cs,
  input logic             err_sequence
);

  logic colcmd;
  assign colcmd = cmd_stb[S_RD] | cmd_stb[S_WR];

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_stb));

  p_multi_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    err_multi_cs |-> (cmd_stb == '0));

  p_autopre_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_autopre |-> colcmd);

  p_preall_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_preall |-> cmd_stb[S_PRE]);

  p_chop_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_chop |-> colcmd);

  p_seq_cmd_r7: assert property (@(posedge clk) disable iff (rst)
    err_sequence |-> (colcmd | cmd_stb[S_ACT]));

  p_mrsel_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_mrsel != 2'b00) |-> cmd_stb[S_MRS]);

  p_col_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_col != '0) |-> colcmd);

endmodule

bind dramcmd_decoder dcd_checker #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .cmd_col(cmd_col),
  .cmd_autopre(cmd_autopre), .cmd_preall(cmd_preall), .cmd_chop(cmd_chop),
  .cmd_mrsel(cmd_mrsel), .err_multi_cs(err_multi_cs), .err_sequence(err_sequence)
);

// File: tb/sim_dramcmd_decoder.sv
`timescale 1ns/1ps
module sim_dramcmd_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  sel_n = 2'b11;
  logic [2:0]  op_n = 3'b111;
  logic [2:0]  bank = '0;
  logic [14:0] addr = '0;

  logic [6:0]  stb;
  logic [0:0]  rnk;
  logic [2:0]  bnk;
  logic [14:0] row;
  logic [10:0] col;
  logic        ap, pall, chop, emul, eseq;
  logic [1:0]  mrs;

  always #2.5 clk = ~clk;

  dramcmd_decoder u0 (
    .clk(clk), .rst(rst), .in_sel_n(sel_n), .in_op_n(op_n), .in_bank(bank),
    .in_addr(addr), .cmd_stb(stb), .cmd_rank(rnk), .cmd_bank(bnk), .cmd_row(row),
    .cmd_col(col), .cmd_autopre(ap), .cmd_preall(pall), .cmd_chop(chop),
    .cmd_mrsel(mrs), .err_multi_cs(emul), .err_sequence(eseq)
  );

  typedef struct packed {
    logic [6:0]  stb;
    logic        rank;
    logic [2:0]  bank;
    logic [14:0] row;
    logic [10:0] col;
    logic        ap, pall, chop;
    logic [1:0]  mrs;
    logic        emul, eseq;
  } exp_t;

  logic        m_open [2][8];
  logic [14:0] m_row  [2][8];
  logic        m_chop [2];
  exp_t        e1, e2;
  int          n_tests = 0;
  int          n_fail  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int r = 0; r < 2; r++) begin
      m_chop[r] = 1'b0;
      for (int b = 0; b < 8; b++) begin
        m_open[r][b] = 1'b0;
        m_row[r][b]  = '0;
      end
    end
  endtask

  function automatic exp_t model(input logic [1:0] s, input logic [2:0] o,
                                 input logic [2:0] b, input logic [14:0] a);
    exp_t e;
    int   r;
    logic rdwr;
    e = '0;
    if (s == 2'b00) begin e.emul = 1'b1; return e; end   // R3
    if (s == 2'b11) return e;                            // R1 masked
    r = s[0] ? 1 : 0;
    case (o)
      3'b011:  e.stb = 7'd1;
      3'b101:  e.stb = 7'd2;
      3'b100:  e.stb = 7'd4;
      3'b010:  e.stb = 7'd8;
      3'b001:  e.stb = 7'd16;
      3'b000:  e.stb = 7'd32;
      3'b110:  e.stb = 7'd64;
      default: return e;
    endcase
    e.rank = r[0];
    rdwr = e.stb[1] | e.stb[2];
    if (e.stb[0] | rdwr | e.stb[3]) e.bank = b;
    if (e.stb[0]) begin
      e.row = a;
      if (m_open[r][b]) e.eseq = 1'b1;
      else begin m_open[r][b] = 1'b1; m_row[r][b] = a; end
    end
    if (rdwr) begin
      e.col  = {a[11], a[9:0]};
      e.row  = m_open[r][b] ? m_row[r][b] : 15'd0;
      e.eseq = !m_open[r][b];
      e.ap   = a[10];
      e.chop = m_chop[r] && !a[12];
      if (a[10]) m_open[r][b] = 1'b0;
    end
    if (e.stb[3]) begin
      e.pall = a[10];
      if (a[10]) for (int k = 0; k < 8; k++) m_open[r][k] = 1'b0;
      else m_open[r][b] = 1'b0;
    end
    if (e.stb[5]) begin
      e.row = a;
      e.mrs = b[1:0];
      if (b == 3'd0) m_chop[r] = (a[1:0] == 2'b01);
    end
    return e;
  endfunction

  task automatic compare(input exp_t x);
    chk("R2 strobe",      32'(stb),  32'(x.stb));
    chk("R1 rank",        32'(rnk),  32'(x.rank));
    chk("R9 bank",        32'(bnk),  32'(x.bank));
    chk("R9 row",         32'(row),  32'(x.row));
    chk("R9 column",      32'(col),  32'(x.col));
    chk("R4 autopre",     32'(ap),   32'(x.ap));
    chk("R5 preall",      32'(pall), 32'(x.pall));
    chk("R6 chop",        32'(chop), 32'(x.chop));
    chk("R8 mrsel",       32'(mrs),  32'(x.mrs));
    chk("R3 multi",       32'(emul), 32'(x.emul));
    chk("R7 sequence",    32'(eseq), 32'(x.eseq));
  endtask

  task automatic step(input logic [1:0] s, input logic [2:0] o,
                      input logic [2:0] b, input logic [14:0] a);
    @(negedge clk);
    compare(e2);
    e2 = e1;
    e1 = model(s, o, b, a);
    sel_n = s; op_n = o; bank = b; addr = a;
  endtask

  task automatic nop();
    step(2'b11, 3'b111, 3'd0, 15'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    sel_n = 2'b10; op_n = 3'b011; bank = 3'd3; addr = 15'h2AAA;
    repeat (3) @(negedge clk);
    chk("R10 reset strobe", 32'(stb), 32'd0);
    chk("R10 reset row",    32'(row), 32'd0);
    chk("R10 reset flags",  32'({emul, eseq, ap, pall, chop}), 32'd0);
    rst = 1'b0;
    sel_n = 2'b11; op_n = 3'b111; bank = '0; addr = '0;
    model_clear();
    e1 = '0; e2 = '0;
  endtask

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    e1 = '0; e2 = '0;
    do_reset();

    // R6: chop enabled on rank0 only
    step(2'b10, 3'b000, 3'd0, 15'h0001);
    step(2'b01, 3'b000, 3'd0, 15'h0000);
    // R8: non-zero mode register index
    step(2'b10, 3'b000, 3'd2, 15'h5A5A);
    // R9/R6/R4: open, chopped read, auto-precharge read, then closed read (R7)
    step(2'b10, 3'b011, 3'd2, 15'h1234);
    step(2'b10, 3'b101, 3'd2, 15'h0ABC);
    step(2'b10, 3'b101, 3'd2, 15'h1C05);
    step(2'b10, 3'b101, 3'd2, 15'h0001);
    // rank1: chop off, duplicate activate is R7
    step(2'b01, 3'b011, 3'd5, 15'h7FFF);
    step(2'b01, 3'b100, 3'd5, 15'h0800);
    step(2'b01, 3'b011, 3'd5, 15'h0101);
    // R3: both selects low
    step(2'b00, 3'b011, 3'd1, 15'h0042);
    // R5: precharge all, then read errors; precharge then activate back to back
    step(2'b01, 3'b010, 3'd0, 15'h0400);
    step(2'b01, 3'b101, 3'd5, 15'h0000);
    step(2'b10, 3'b011, 3'd6, 15'h0066);
    step(2'b10, 3'b010, 3'd6, 15'h0000);
    step(2'b10, 3'b011, 3'd6, 15'h0077);
    step(2'b10, 3'b100, 3'd6, 15'h1400);
    // R1: masked read on a closed bank leaves no trace
    step(2'b11, 3'b101, 3'd6, 15'h0000);
    nop(); nop();
    chk("R1 masked strobe", 32'(stb), 32'd0);
    chk("R1 masked flag",   32'(eseq), 32'd0);
    step(2'b11, 3'b011, 3'd4, 15'h0011);
    step(2'b10, 3'b101, 3'd4, 15'h0000);
    nop(); nop();

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] pick;
      logic [1:0] s;
      pick = 4'($urandom % 16);
      if (pick == 0)      s = 2'b00;
      else if (pick < 3)  s = 2'b11;
      else                s = pick[0] ? 2'b10 : 2'b01;
      step(s, 3'($urandom % 8), 3'($urandom % 8), 15'($urandom));
    end
    nop(); nop();

    // R10: reset closes banks mid-run
    step(2'b10, 3'b011, 3'd3, 15'h0333);
    nop(); nop();
    do_reset();
    step(2'b10, 3'b101, 3'd3, 15'h0000);
    nop(); nop();
    chk("R10 bank closed by reset", 32'(eseq), 32'd1);
    nop(); nop();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule